// File: doc/BRIEF.md
# Channel Result Store with Processor Read Port

This block holds the most recent conversion result for each of eight input channels. A conversion sequencer deposits results through a request/acknowledge strobe. A microprocessor reads any channel at any moment through an address, an address-latch enable, an active-low chip select and an 8-bit data output. A separate output-enable models the three-state drivers.

The processor's address is either followed live or frozen, depending on the latch enable. A converter write is parked in a one-entry buffer and committed only on a clock edge at which chip select is high. The processor therefore never sees a word change during its access, and it never waits for the converter. While the output is disabled the data lines read as zero.

Top module: `chan_result_store`

## Requirements
- R1: After reset all eight words read as 0x00, `rd_oe_o` is 0, `rd_data_o` is 0x00 and `wr_ack_o` is 0.
- R2: The read address is plain binary: value n (0..7) selects the word written for channel n, and a read returns the last committed value for that channel.
- R3: While `ale_i` is 1 the latch is transparent: the address present at a sampling edge is used for the read made at that same edge.
- R4: After `ale_i` falls, the address held is the one present at the last edge with `ale_i` at 1. Later changes of `addr_i` do not alter the word that is read.
- R5: `rd_oe_o` equals the inverse of `cs_ni` as sampled at the previous clock edge. When `rd_oe_o` is 0, `rd_data_o` is 0x00. When `rd_oe_o` is 1, `rd_data_o` is the word selected at that edge.
- R6: A write request is captured at the edge where `wr_req_i` is 1. It is committed on the first later edge at which `cs_ni` is 1, and `wr_ack_o` is 1 for the cycle that follows that edge only. No commit happens at an edge with `cs_ni` at 0.
- R7: A read held across a pending write keeps returning the complete previous word of that address until the write is committed.
- R8: With `cs_ni` held at 1, a request sampled at edge k is committed at edge k+1, and `wr_ack_o` is 1 in the cycle after edge k+1.
- R9: While `cs_ni` stays 0 and `ale_i` stays 0 across consecutive edges, `rd_data_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Converter write request, sampled each edge |
| wr_addr_i | input | 3 | Channel of the result being written |
| wr_data_i | input | 8 | Result value |
| wr_ack_o | output | 1 | One-cycle pulse after the write is committed |
| ale_i | input | 1 | Address latch enable; 1 = transparent, 0 = hold |
| addr_i | input | 3 | Processor read address |
| cs_ni | input | 1 | Chip select, active low |
| rd_data_o | output | 8 | Registered read data (0 while disabled) |
| rd_oe_o | output | 1 | Output-driver enable |

## Verification
A converter commit and a processor read compete for the same word. The bench opens a read on a channel and holds chip select low. It then issues a write to that same channel and keeps the read open for several edges. During that time the output must keep showing the old word and no acknowledge may appear. After chip select is released, the commit and its acknowledge must land on the first high edge, and a fresh read must return the new value.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_AW = 3;
  localparam int unsigned RS_DW = 8;
endpackage

// File: rtl/rs_addr_latch.sv
module rs_addr_latch #(
  parameter int unsigned AW = rs_pkg::RS_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] held_q;

  // transparent while enabled, else last passed value
  assign addr_o = ale_i ? addr_i : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= addr_o;
  end
endmodule

// File: rtl/rs_wr_buffer.sv
module rs_wr_buffer #(
  parameter int unsigned AW = rs_pkg::RS_AW,
  parameter int unsigned DW = rs_pkg::RS_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          cs_ni,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o,
  output logic          ack_o
);
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // commit only on edges where the processor is off the bus
  assign commit_o      = pend_q & cs_ni;
  assign commit_addr_o = addr_q;
  assign commit_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      ack_o  <= 1'b0;
    end else begin
      ack_o <= commit_o;
      if (req_i) begin
        pend_q <= 1'b1;
        addr_q <= addr_i;
        data_q <= data_i;
      end else if (commit_o) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_mem.sv
module rs_mem #(
  parameter int unsigned AW = rs_pkg::RS_AW,
  parameter int unsigned DW = rs_pkg::RS_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 word_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))        word_q[g] <= wdata_i;
    end
  end

  assign rdata_o = word_q[raddr_i];
endmodule

// File: rtl/chan_result_store.sv
module chan_result_store #(
  parameter int unsigned AW = rs_pkg::RS_AW,
  parameter int unsigned DW = rs_pkg::RS_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ack_o,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  input  logic          cs_ni,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_oe_o
);
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_word;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [DW-1:0] commit_data;

  rs_addr_latch #(.AW(AW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .addr_i (addr_i),
    .addr_o (rd_addr)
  );

  rs_wr_buffer #(.AW(AW), .DW(DW)) u_wbuf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (wr_req_i),
    .addr_i        (wr_addr_i),
    .data_i        (wr_data_i),
    .cs_ni         (cs_ni),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_data_o (commit_data),
    .ack_o         (wr_ack_o)
  );

  rs_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (commit),
    .waddr_i (commit_addr),
    .wdata_i (commit_data),
    .raddr_i (rd_addr),
    .rdata_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_oe_o   <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_oe_o   <= ~cs_ni;
      rd_data_o <= cs_ni ? '0 : rd_word;
    end
  end
endmodule

// File: rtl/chan_result_store_chk.sv
module chan_result_store_chk #(
  parameter int unsigned AW = rs_pkg::RS_AW,
  parameter int unsigned DW = rs_pkg::RS_DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_ack_o,
  input logic          ale_i,
  input logic          cs_ni,
  input logic [DW-1:0] rd_data_o,
  input logic          rd_oe_o
);
  a_r6_ack_only_after_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> $past(cs_ni));

  a_r5_oe_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |=> rd_oe_o);

  a_r5_oe_off_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !rd_oe_o);

  a_r5_zero_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> (rd_data_o == '0));

  a_r9_stable_during_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !ale_i && $past(!cs_ni) && $past(!ale_i)) |=> $stable(rd_data_o));
endmodule

bind chan_result_store chan_result_store_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_ack_o  (wr_ack_o),
  .ale_i     (ale_i),
  .cs_ni     (cs_ni),
  .rd_data_o (rd_data_o),
  .rd_oe_o   (rd_oe_o)
);

// File: tb/chan_result_store_tb_top.sv
module chan_result_store_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_ack;
  logic       ale = 1'b1;
  logic [2:0] addr = '0;
  logic       cs_n = 1'b1;
  logic [7:0] rd_data;
  logic       rd_oe;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] model [8];
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_result_store dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_ack_o(wr_ack),
    .ale_i(ale), .addr_i(addr), .cs_ni(cs_n),
    .rd_data_o(rd_data), .rd_oe_o(rd_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // R8: request at edge k, commit at k+1 with cs high, ack in following cycle
  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_req = 1'b0;
    check("R8 ack low after capture", {7'b0, wr_ack}, 8'h00);
    @(negedge clk);
    check("R8 ack after commit", {7'b0, wr_ack}, 8'h01);
    model[a] = d;
    @(negedge clk);
    check("R6 ack single cycle", {7'b0, wr_ack}, 8'h00);
  endtask

  // R3: ale high, address used at the same edge
  task automatic do_read(input logic [2:0] a, input string tag);
    @(negedge clk); cs_n = 1'b0; ale = 1'b1; addr = a;
    @(negedge clk);
    check({tag, " oe"}, {7'b0, rd_oe}, 8'h01);
    check(tag, rd_data, model[a]);
    cs_n = 1'b1;
    @(negedge clk);
    check("R5 oe drops", {7'b0, rd_oe}, 8'h00);
    check("R5 data zero when off", rd_data, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 oe reset", {7'b0, rd_oe}, 8'h00);
    check("R1 data reset", rd_data, 8'h00);
    check("R1 ack reset", {7'b0, wr_ack}, 8'h00);
    for (int i = 0; i < 8; i++) do_read(3'(i), "R1 word reset");

    // R2/R3 sweep over patterns and all channels
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) do_write(3'(i), 8'((i * 37 + p * 91 + 5) ^ (p[0] ? 8'hFF : 8'h00)));
      for (int i = 7; i >= 0; i--) do_read(3'(i), "R2 R3 channel read");
    end
    do_write(3'd4, 8'hFF); do_read(3'd4, "R2 all ones");
    do_write(3'd4, 8'h00); do_read(3'd4, "R2 all zeros");

    // R4: latch holds after ale falls
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ale = 1'b1; addr = 3'(i);
      @(negedge clk); ale = 1'b0; addr = 3'(7 - i); cs_n = 1'b0;
      @(negedge clk);
      check("R4 held address", rd_data, model[i]);
      addr = 3'(i + 3);
      @(negedge clk);
      check("R4 address change ignored", rd_data, model[i]);
      cs_n = 1'b1; ale = 1'b1;
      @(negedge clk);
    end

    // R6/R7: write to the channel being read while cs low
    @(negedge clk); cs_n = 1'b0; ale = 1'b1; addr = 3'd2;
    @(negedge clk); ale = 1'b0;
    check("R7 old word before write", rd_data, model[2]);
    wr_req = 1'b1; wr_addr = 3'd2; wr_data = ~model[2];
    @(negedge clk); wr_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R6 no ack while selected", {7'b0, wr_ack}, 8'h00);
      check("R7 old word while pending", rd_data, model[2]);
      @(negedge clk);
    end
    cs_n = 1'b1; ale = 1'b1;
    @(negedge clk);
    check("R6 ack on first idle edge", {7'b0, wr_ack}, 8'h01);
    model[2] = ~model[2];
    @(negedge clk);
    check("R6 ack one cycle", {7'b0, wr_ack}, 8'h00);
    do_read(3'd2, "R6 committed value");
    for (int i = 0; i < 8; i++) do_read(3'(i), "R7 others intact");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule